// File: doc/BRIEF.md
# Polled Sector Transfer Engine

This block runs the data phase of a single-sector read or write for a floppy-style controller. The host sees four byte-wide registers: command/status, track, sector and data. Issuing a read or write command starts the engine. After a short fixed settling period it watches the disk-side byte stream for ID headers and compares each one against the track and sector registers. Only a matching header opens the data phase, and then a fixed number of bytes moves between the stream and the data register.

There is no interrupt and no DMA. The host paces everything by polling one data-request status bit. On a read, that bit means a fresh byte is waiting in the data register. On a write, it means the engine needs the next byte. Each byte has a hard deadline set by the stream. If the stream moves on while a request is still pending, a lost-data flag records the overrun and the command keeps going. A command that sees too many non-matching headers ends with a not-found flag. The track register is only ever compared with header contents and never drives head movement.

Top module: `sxe_engine`

## Requirements
- R1: After reset the status register reads 0x00, `motor_on` is 0 and `tx_valid` is 0.
- R2: Writing 0x88 (read) or 0xA8 (write) to address 0 while idle starts a command. The command sets status bit 0 (busy) and `motor_on`, and clears status bits 2 and 4. A write of any other code, or any command write while busy, has no effect.
- R3: For SETTLE_CYC cycles after a command starts, stream bytes are ignored, and status shows busy with bit 1 clear.
- R4: An ID header is a stream byte flagged by `rx_mark` (the track field) followed by the next stream byte (the sector field). The data phase starts only when both fields equal the track (address 1) and sector (address 2) registers.
- R5: After MAX_IDS consecutive non-matching headers, the command ends: busy clears and status bit 4 (record not found) is set.
- R6: During a read, each stream byte in the data phase is loaded into the data register (address 3) and sets status bit 1. A host read of address 3 clears bit 1.
- R7: During a write, bit 1 is set on entering the data phase and after each byte taken except the last. A host write to address 3 loads the byte and clears bit 1. A `tx_ready` pulse in the data phase raises `tx_valid` in the same cycle, with `tx_byte` equal to the data register.
- R8: A stream byte (read) or a `tx_ready` (write) that arrives while bit 1 is still set sets status bit 2 (lost data), and the transfer continues. A host read of address 3 in the same cycle as an arriving byte prevents the overrun.
- R9: Busy stays set until the last of SECT_BYTES bytes is transferred: on a read, until the host reads the last byte; on a write, until the stream takes the last byte.
- R10: Writes to addresses 1 and 2 while idle are read back unchanged from those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 command/status, 1 track, 2 sector, 3 data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (only reads of address 3 have side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by `host_addr` |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_mark | input | 1 | The present stream byte begins an ID header |
| rx_byte | input | 8 | Stream byte from the disk side |
| tx_ready | input | 1 | The disk side takes a write byte this cycle |
| tx_valid | output | 1 | The byte on `tx_byte` is delivered this cycle |
| tx_byte | output | 8 | Write byte to the disk side |
| motor_on | output | 1 | Set by an accepted command |

## Verification
The hardest situation to reach is a host read of the data register in the same clock cycle that the next stream byte arrives. In that cycle the clear and the new request collide, and the outcome must count as a timely hand-off, not an overrun. The bench drives both strobes from one task in the same cycle. It then checks that the old byte was returned, that a new request is pending and that the lost flag is still clear. It contrasts this with a stream byte sent one cycle with no host read, which must raise the flag.

// File: rtl/sxe_pkg.sv
package sxe_pkg;

    localparam logic [7:0] CMD_READ  = 8'h88;
    localparam logic [7:0] CMD_WRITE = 8'hA8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEEK,
        ST_IDSEC,
        ST_XFER,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        state_e     st;
        logic       wr_mode;
        logic       drq;
        logic       lost;
        logic       rnf;
        logic       motor;
        logic [7:0] trk;
        logic [7:0] sec;
        logic [7:0] data;
        logic [7:0] hdr_trk;
    } regs_t;

endpackage

// File: rtl/sxe_counter.sv
module sxe_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && !at_last)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == W'(LIMIT - 1));

    // count never passes its limit, which bounds transfer length (R9)
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= W'(LIMIT - 1)));
endmodule

// File: rtl/sxe_id_check.sv
module sxe_id_check (
    input  logic [7:0] want_trk,
    input  logic [7:0] want_sec,
    input  logic [7:0] hdr_trk,
    input  logic [7:0] hdr_sec,
    output logic       hit
);
    assign hit = (want_trk == hdr_trk) && (want_sec == hdr_sec);
endmodule

// File: rtl/sxe_engine.sv
module sxe_engine
    import sxe_pkg::*;
#(
    parameter int SECT_BYTES = 256,
    parameter int MAX_IDS    = 8,
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       rx_valid,
    input  logic       rx_mark,
    input  logic [7:0] rx_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       motor_on
);
    regs_t cur_q, nxt_d;

    logic settle_clr, settle_inc, settle_last;
    logic ids_clr, ids_inc, ids_last;
    logic byte_clr, byte_inc, byte_last;
    logic id_hit, busy, host_clr, drq_eff, start, wr_cmd;
    logic [7:0] status;

    sxe_counter #(.LIMIT(SETTLE_CYC)) settle_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(settle_clr), .inc(settle_inc), .at_last(settle_last));
    sxe_counter #(.LIMIT(MAX_IDS)) ids_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(ids_clr), .inc(ids_inc), .at_last(ids_last));
    sxe_counter #(.LIMIT(SECT_BYTES)) byte_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(byte_clr), .inc(byte_inc), .at_last(byte_last));

    sxe_id_check id_check_i (
        .want_trk(cur_q.trk), .want_sec(cur_q.sec),
        .hdr_trk(cur_q.hdr_trk), .hdr_sec(rx_byte), .hit(id_hit));

    assign busy     = (cur_q.st != ST_IDLE);
    assign wr_cmd   = host_wr && (host_addr == 2'd0);
    assign start    = wr_cmd && !busy &&
                      ((host_wdata == CMD_READ) || (host_wdata == CMD_WRITE));
    assign host_clr = cur_q.drq && busy && (host_addr == 2'd3) &&
                      (cur_q.wr_mode ? host_wr : host_rd);
    assign drq_eff  = cur_q.drq && !host_clr;
    assign tx_valid = tx_ready && (cur_q.st == ST_XFER) && cur_q.wr_mode;
    assign tx_byte  = cur_q.data;
    assign motor_on = cur_q.motor;
    assign status   = {3'b000, cur_q.rnf, 1'b0, cur_q.lost, cur_q.drq, busy};

    always_comb begin
        case (host_addr)
            2'd0:    host_rdata = status;
            2'd1:    host_rdata = cur_q.trk;
            2'd2:    host_rdata = cur_q.sec;
            default: host_rdata = cur_q.data;
        endcase
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.drq  = drq_eff;
        settle_clr = 1'b0;
        settle_inc = 1'b0;
        ids_clr    = 1'b0;
        ids_inc    = 1'b0;
        byte_clr   = 1'b0;
        byte_inc   = 1'b0;

        if (host_wr && !busy && host_addr == 2'd1) nxt_d.trk = host_wdata;
        if (host_wr && !busy && host_addr == 2'd2) nxt_d.sec = host_wdata;
        if (host_wr && host_addr == 2'd3 && !(busy && !cur_q.wr_mode))
            nxt_d.data = host_wdata;

        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st      = ST_SETTLE;
                    nxt_d.wr_mode = (host_wdata == CMD_WRITE);
                    nxt_d.drq     = 1'b0;
                    nxt_d.lost    = 1'b0;
                    nxt_d.rnf     = 1'b0;
                    nxt_d.motor   = 1'b1;
                    settle_clr    = 1'b1;
                    ids_clr       = 1'b1;
                    byte_clr      = 1'b1;
                end
            end
            ST_SETTLE: begin
                settle_inc = 1'b1;
                if (settle_last) nxt_d.st = ST_SEEK;
            end
            ST_SEEK: begin
                if (rx_valid && rx_mark) begin
                    nxt_d.hdr_trk = rx_byte;
                    nxt_d.st      = ST_IDSEC;
                end
            end
            ST_IDSEC: begin
                if (rx_valid) begin
                    if (id_hit) begin
                        nxt_d.st  = ST_XFER;
                        nxt_d.drq = cur_q.wr_mode;
                        byte_clr  = 1'b1;
                    end else if (ids_last) begin
                        nxt_d.st  = ST_IDLE;
                        nxt_d.rnf = 1'b1;
                    end else begin
                        ids_inc  = 1'b1;
                        nxt_d.st = ST_SEEK;
                    end
                end
            end
            ST_XFER: begin
                if (!cur_q.wr_mode && rx_valid) begin
                    nxt_d.data = rx_byte;
                    nxt_d.drq  = 1'b1;
                    if (drq_eff) nxt_d.lost = 1'b1;
                    byte_inc = 1'b1;
                    if (byte_last) nxt_d.st = ST_DRAIN;
                end else if (cur_q.wr_mode && tx_ready) begin
                    if (cur_q.drq) nxt_d.lost = 1'b1;
                    byte_inc = 1'b1;
                    if (byte_last) begin
                        nxt_d.st  = ST_IDLE;
                        nxt_d.drq = 1'b0;
                    end else begin
                        nxt_d.drq = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (!drq_eff) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, default: '0};
        else        cur_q <= nxt_d;
    end

    // request flag only while a command is active (R9)
    assert_drq_in_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.drq |-> busy);
    // a running command always has the motor on (R2)
    assert_motor_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> motor_on);
    // settling leads only to header search (R3)
    assert_settle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SETTLE) |=> (cur_q.st == ST_SETTLE || cur_q.st == ST_SEEK));
    // not-found always ends the command (R5)
    assert_rnf_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.rnf) |-> !busy);
    // read overrun without host read raises lost flag (R8)
    assert_read_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_XFER && !cur_q.wr_mode && rx_valid && cur_q.drq &&
         !(host_rd && host_addr == 2'd3)) |=> cur_q.lost);
    // a delivered non-final write byte re-arms the request (R7)
    assert_tx_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !byte_last) |=> cur_q.drq);
endmodule

// File: tb/sxe_engine_tb_top.sv
module sxe_engine_tb_top;
    localparam int SB = 4;
    localparam int NI = 3;
    localparam int ST = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_valid = 1'b0, rx_mark = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_ready = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       motor_on;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sxe_engine #(.SECT_BYTES(SB), .MAX_IDS(NI), .SETTLE_CYC(ST)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_mark(rx_mark), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .motor_on(motor_on));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        host_addr = a; #1;
        v = host_rdata;
    endtask

    task automatic hread_data(output logic [7:0] v);
        host_addr = 2'd3; host_rd = 1'b1; #1;
        v = host_rdata;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic rx_send(input logic m, input logic [7:0] b);
        rx_valid = 1'b1; rx_mark = m; rx_byte = b;
        tick();
        rx_valid = 1'b0; rx_mark = 1'b0;
    endtask

    task automatic header(input logic [7:0] t, input logic [7:0] s);
        rx_send(1'b1, t);
        rx_send(1'b0, s);
    endtask

    task automatic chk_status(input string tag, input int exp);
        logic [7:0] v;
        peek(2'd0, v);
        chk(tag, int'(v), exp);
    endtask

    task automatic start_cmd(input logic [7:0] t, input logic [7:0] s, input logic [7:0] c);
        hwrite(2'd1, t);
        hwrite(2'd2, s);
        hwrite(2'd0, c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=0x1 expected=0x0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk_status("R1 status", 0);
        chk("R1 motor", int'(motor_on), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);

        // R10 register readback; R2 unknown code ignored
        hwrite(2'd1, 8'h5A); hwrite(2'd2, 8'hC3);
        peek(2'd1, v); chk("R10 track", int'(v), 8'h5A);
        peek(2'd2, v); chk("R10 sector", int'(v), 8'hC3);
        hwrite(2'd0, 8'h10);
        chk_status("R2 unknown cmd", 0);
        chk("R2 motor stays off", int'(motor_on), 0);

        // R4 R6 R9 read sweep over sectors with mismatching headers first
        for (int s = 0; s < 4; s++) begin
            start_cmd(8'd5, 8'(s), 8'h88);
            chk_status("R2 read start", 8'h01);
            chk("R2 motor", int'(motor_on), 1);
            repeat (ST) tick();
            header(8'd5, 8'((s + 1) % 4));
            header(8'd6, 8'(s));
            chk_status("R4 no match yet", 8'h01);
            header(8'd5, 8'(s));
            chk_status("R4 matched no drq", 8'h01);
            for (int i = 0; i < SB; i++) begin
                rx_send(1'b0, 8'(s * 16 + i * 3 + 1));
                chk_status("R6 drq set", 8'h03);
                hread_data(v);
                chk("R6 data", int'(v), s * 16 + i * 3 + 1);
                chk_status("R9 after read", (i == SB - 1) ? 8'h00 : 8'h01);
            end
        end

        // R3 stream ignored while settling
        start_cmd(8'd2, 8'd1, 8'h88);
        header(8'd2, 8'd1);
        tick();
        rx_send(1'b0, 8'h77);
        chk_status("R3 settle ignored", 8'h01);
        header(8'd2, 8'd1);
        rx_send(1'b0, 8'h40);
        chk_status("R3 after settle", 8'h03);
        // R2 command while busy ignored
        hwrite(2'd0, 8'hA8);
        tx_ready = 1'b1; #1;
        chk("R2 busy cmd ignored", int'(tx_valid), 0);
        tick(); tx_ready = 1'b0;
        hread_data(v); chk("R6 data", int'(v), 8'h40);
        // R8 same-cycle host read and new byte: no overrun
        rx_send(1'b0, 8'h41);
        host_addr = 2'd3; host_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h42; #1;
        v = host_rdata;
        tick();
        host_rd = 1'b0; rx_valid = 1'b0;
        chk("R8 same-cycle old byte", int'(v), 8'h41);
        chk_status("R8 same-cycle no lost", 8'h03);
        // R8 overrun: last byte arrives unread
        rx_send(1'b0, 8'h43);
        chk_status("R8 overrun", 8'h07);
        hread_data(v); chk("R8 newest byte", int'(v), 8'h43);
        chk_status("R9 end keeps lost", 8'h04);
        // R2 new command clears lost
        start_cmd(8'd2, 8'd1, 8'h88);
        chk_status("R2 lost cleared", 8'h01);
        repeat (ST) tick();

        // R5 not found after NI mismatches
        for (int k = 0; k < NI; k++) begin
            chk_status("R5 still busy", 8'h01);
            header(8'd2, 8'(k + 2));
        end
        chk_status("R5 not found", 8'h10);

        // R7 R9 write sweep
        for (int s = 0; s < 4; s++) begin
            start_cmd(8'd9, 8'(s), 8'hA8);
            chk_status("R2 write start", 8'h01);
            repeat (ST) tick();
            header(8'd9, 8'(s));
            chk_status("R7 first request", 8'h03);
            for (int i = 0; i < SB; i++) begin
                hwrite(2'd3, 8'((s * 37 + i * 11) & 8'hFF));
                chk_status("R7 drq cleared", 8'h01);
                tx_ready = 1'b1; #1;
                chk("R7 tx_valid", int'(tx_valid), 1);
                chk("R7 tx_byte", int'(tx_byte), (s * 37 + i * 11) & 8'hFF);
                tick(); tx_ready = 1'b0;
                chk_status("R9 write progress", (i == SB - 1) ? 8'h00 : 8'h03);
            end
        end

        // R8 write underrun
        start_cmd(8'd1, 8'd0, 8'hA8);
        repeat (ST) tick();
        header(8'd1, 8'd0);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        chk_status("R8 write underrun", 8'h07);
        for (int i = 1; i < SB; i++) begin
            hwrite(2'd3, 8'(i));
            tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        end
        chk_status("R9 underrun completes", 8'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule